// File: doc/BRIEF.md
# Header-credit throttle with link-drop counter

This block sits in the transmit path of a serial link. It holds a count of the header credits that the link partner has granted, one count for posted requests and one for non-posted requests. Each count loads from the partner's advertised grant when the link comes up. It goes down by one for each request sent and up by one for each credit returned. Software programs a minimum for each class. While the count for a class is below its minimum, the block raises that class's throttle output to stop the upstream request source.

A minimum that is larger than the partner's grant would stall its class for good. To prevent this, the block lowers each minimum to the grant value on every link-up. A second part of the block counts how often the link has dropped from up to down. That count clears when software reads it.

Top module: `credit_throttle`

## Requirements
- R1: Once `ready_o` is high, `p_throttle_o` is 1 whenever the posted credit count is below `p_thr_o`, and 0 otherwise.
- R2: Once `ready_o` is high, `np_throttle_o` is 1 whenever the non-posted credit count is below `np_thr_o`, and 0 otherwise.
- R3: Each threshold is 8 bits wide. `thr_we_i[0]` writes `thr_wdata_i` to the posted threshold and `thr_we_i[1]` writes it to the non-posted threshold. The new value shows on `p_thr_o`/`np_thr_o` in the next cycle. A write made while the link stays up is not clamped.
- R4: A link-up edge is the first cycle with `link_up_i` high after it was low. On that edge each credit count loads its `init_*_cred_i` value, and each threshold becomes the smaller of its current value (or the value being written in that cycle) and that initial grant. The result is that neither class is throttled in the first cycle after the edge.
- R5: `ready_o` follows `link_up_i` one cycle later. While `link_up_i` is low, both credit counts are zero from the next cycle on and both throttle outputs are 1 whenever `ready_o` is 0.
- R6: While the link is up, a return pulse adds one credit and stops at 255. A consume pulse removes one credit and stops at 0. A consume and a return in the same cycle cancel each other.
- R7: A consume pulse with no return while the class count is zero raises that class's `*_cred_err_o` for the next cycle only.
- R8: The link-drop counter goes up by one for each cycle in which `ready_o` is 1 and `link_up_i` is 0. It stops at 127.
- R9: A pulse on `drop_rd_i` sets the link-drop counter to 0 in the next cycle. If a drop happens in the same cycle as the read, the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link is up |
| init_p_cred_i | input | 8 | Posted header credits granted at link-up |
| init_np_cred_i | input | 8 | Non-posted header credits granted at link-up |
| p_consume_i | input | 1 | One posted credit used |
| p_return_i | input | 1 | One posted credit returned |
| np_consume_i | input | 1 | One non-posted credit used |
| np_return_i | input | 1 | One non-posted credit returned |
| thr_we_i | input | 2 | Threshold write enables: bit 0 posted, bit 1 non-posted |
| thr_wdata_i | input | 8 | Threshold write value |
| drop_rd_i | input | 1 | Read strobe that clears the link-drop counter |
| ready_o | output | 1 | Port ready for traffic |
| p_throttle_o | output | 1 | Posted almost-full |
| np_throttle_o | output | 1 | Non-posted almost-full |
| p_thr_o | output | 8 | Effective posted threshold |
| np_thr_o | output | 8 | Effective non-posted threshold |
| p_cred_err_o | output | 1 | Posted consume seen with no credit |
| np_cred_err_o | output | 1 | Non-posted consume seen with no credit |
| drop_cnt_o | output | 7 | Link-drop count |

## Verification
The assertions check these on every cycle: a count at its limit does not overflow or underflow, counts are zero after the link goes down, a clamped threshold never exceeds the new count at link-up, threshold writes are captured, and the drop counter clears, reloads and saturates as specified. Only the bench scenarios show the cycle-exact throttle value over long mixed consume/return streams. The same is true for a threshold write that lands in the link-up cycle, and for saturation of the drop counter reached after more than a hundred link drops.

// File: rtl/credit_throttle_pkg.sv
package credit_throttle_pkg;
  localparam int unsigned CRED_W_DEF = 8;
  localparam int unsigned DROP_W_DEF = 7;
  localparam int unsigned NUM_CLS    = 2;
  localparam int unsigned CLS_P      = 0;
  localparam int unsigned CLS_NP     = 1;

  function automatic logic [CRED_W_DEF-1:0] min_cred(
    input logic [CRED_W_DEF-1:0] a,
    input logic [CRED_W_DEF-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/credit_pool.sv
module credit_pool #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_i,
  input  logic          ready_i,
  input  logic [CW-1:0] init_i,
  input  logic          consume_i,
  input  logic          return_i,
  input  logic          thr_we_i,
  input  logic [CW-1:0] thr_wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] thr_o,
  output logic          throttle_o,
  output logic          err_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d, thr_q, thr_d, thr_src;
  logic          err_q, rise;

  assign rise = link_i & ~ready_i;

  always_comb begin
    thr_src = thr_we_i ? thr_wdata_i : thr_q;
    thr_d   = (rise && (init_i < thr_src)) ? init_i : thr_src;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!link_i)                                     cnt_d = '0;
    else if (rise)                                   cnt_d = init_i;
    else if (consume_i && !return_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else if (return_i && !consume_i && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      thr_q <= thr_d;
      err_q <= consume_i & ~return_i & (cnt_q == '0);
    end
  end

  assign cnt_o      = cnt_q;
  assign thr_o      = thr_q;
  assign err_o      = err_q;
  assign throttle_o = ~ready_i | (cnt_q < thr_q);
endmodule

// File: rtl/link_drop_ctr.sv
module link_drop_ctr #(
  parameter int unsigned DW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          rd_i,
  output logic [DW-1:0] cnt_o
);
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (rd_i)                 cnt_q <= inc_i ? ONE : '0;
    else if (inc_i && cnt_q != DMAX) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/credit_throttle.sv
module credit_throttle
  import credit_throttle_pkg::*;
#(
  parameter int unsigned CRED_W = CRED_W_DEF,
  parameter int unsigned DROP_W = DROP_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic [CRED_W-1:0] init_p_cred_i,
  input  logic [CRED_W-1:0] init_np_cred_i,
  input  logic              p_consume_i,
  input  logic              p_return_i,
  input  logic              np_consume_i,
  input  logic              np_return_i,
  input  logic [1:0]        thr_we_i,
  input  logic [CRED_W-1:0] thr_wdata_i,
  input  logic              drop_rd_i,
  output logic              ready_o,
  output logic              p_throttle_o,
  output logic              np_throttle_o,
  output logic [CRED_W-1:0] p_thr_o,
  output logic [CRED_W-1:0] np_thr_o,
  output logic              p_cred_err_o,
  output logic              np_cred_err_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              link_q;
  logic [CRED_W-1:0] init_w [NUM_CLS];
  logic [CRED_W-1:0] cnt_w  [NUM_CLS];
  logic [CRED_W-1:0] thr_w  [NUM_CLS];
  logic              cons_w [NUM_CLS];
  logic              ret_w  [NUM_CLS];
  logic              thrt_w [NUM_CLS];
  logic              err_w  [NUM_CLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_up_i;
  end

  assign init_w[CLS_P]  = init_p_cred_i;
  assign init_w[CLS_NP] = init_np_cred_i;
  assign cons_w[CLS_P]  = p_consume_i;
  assign cons_w[CLS_NP] = np_consume_i;
  assign ret_w[CLS_P]   = p_return_i;
  assign ret_w[CLS_NP]  = np_return_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    credit_pool #(.CW(CRED_W)) i_pool (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .link_i      (link_up_i),
      .ready_i     (link_q),
      .init_i      (init_w[c]),
      .consume_i   (cons_w[c]),
      .return_i    (ret_w[c]),
      .thr_we_i    (thr_we_i[c]),
      .thr_wdata_i (thr_wdata_i),
      .cnt_o       (cnt_w[c]),
      .thr_o       (thr_w[c]),
      .throttle_o  (thrt_w[c]),
      .err_o       (err_w[c])
    );
  end

  link_drop_ctr #(.DW(DROP_W)) i_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (link_q & ~link_up_i),
    .rd_i   (drop_rd_i),
    .cnt_o  (drop_cnt_o)
  );

  assign ready_o       = link_q;
  assign p_throttle_o  = thrt_w[CLS_P];
  assign np_throttle_o = thrt_w[CLS_NP];
  assign p_thr_o       = thr_w[CLS_P];
  assign np_thr_o      = thr_w[CLS_NP];
  assign p_cred_err_o  = err_w[CLS_P];
  assign np_cred_err_o = err_w[CLS_NP];
endmodule

// File: rtl/credit_throttle_chk.sv
module credit_throttle_chk #(
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          link_up_i,
  input logic          p_consume_i,
  input logic          p_return_i,
  input logic          np_consume_i,
  input logic          np_return_i,
  input logic [1:0]    thr_we_i,
  input logic [CW-1:0] thr_wdata_i,
  input logic          drop_rd_i,
  input logic          ready_o,
  input logic          p_throttle_o,
  input logic          np_throttle_o,
  input logic [CW-1:0] p_thr_o,
  input logic [CW-1:0] np_thr_o,
  input logic          p_cred_err_o,
  input logic [DW-1:0] drop_cnt_o,
  input logic [CW-1:0] p_cnt_i,
  input logic [CW-1:0] np_cnt_i
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [DW-1:0] DMAX = '1;

  assert_p_throttle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && link_up_i && p_consume_i && !p_return_i && p_cnt_i == p_thr_o && p_cnt_i != '0
    |=> p_throttle_o);

  assert_np_throttle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && link_up_i && np_consume_i && !np_return_i && np_cnt_i == np_thr_o && np_cnt_i != '0
    |=> np_throttle_o);

  assert_thr_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && link_up_i && thr_we_i[0] |=> p_thr_o == $past(thr_wdata_i));

  assert_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> p_thr_o <= p_cnt_i && np_thr_o <= np_cnt_i
                       && !p_throttle_o && !np_throttle_o);

  assert_down_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> p_cnt_i == '0 && np_cnt_i == '0 && p_throttle_o && np_throttle_o);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && link_up_i && np_return_i && !np_consume_i && np_cnt_i == CMAX |=> np_cnt_i == CMAX);

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && link_up_i && p_consume_i && !p_return_i && p_cnt_i == '0
    |=> p_cnt_i == '0 && p_cred_err_o);

  assert_drop_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !link_up_i && !drop_rd_i && drop_cnt_o == DMAX |=> drop_cnt_o == DMAX);

  assert_drop_rd_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_rd_i && ready_o && !link_up_i |=> drop_cnt_o == DW'(1));

  assert_drop_rd_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_rd_i && !(ready_o && !link_up_i) |=> drop_cnt_o == '0);
endmodule

bind credit_throttle credit_throttle_chk #(.CW(CRED_W), .DW(DROP_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .link_up_i     (link_up_i),
  .p_consume_i   (p_consume_i),
  .p_return_i    (p_return_i),
  .np_consume_i  (np_consume_i),
  .np_return_i   (np_return_i),
  .thr_we_i      (thr_we_i),
  .thr_wdata_i   (thr_wdata_i),
  .drop_rd_i     (drop_rd_i),
  .ready_o       (ready_o),
  .p_throttle_o  (p_throttle_o),
  .np_throttle_o (np_throttle_o),
  .p_thr_o       (p_thr_o),
  .np_thr_o      (np_thr_o),
  .p_cred_err_o  (p_cred_err_o),
  .drop_cnt_o    (drop_cnt_o),
  .p_cnt_i       (cnt_w[0]),
  .np_cnt_i      (cnt_w[1])
);

// File: tb/test_credit_throttle.sv
module test_credit_throttle;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       link_up_i = 1'b0;
  logic [7:0] init_p_cred_i = '0, init_np_cred_i = '0;
  logic       p_consume_i = 1'b0, p_return_i = 1'b0;
  logic       np_consume_i = 1'b0, np_return_i = 1'b0;
  logic [1:0] thr_we_i = '0;
  logic [7:0] thr_wdata_i = '0;
  logic       drop_rd_i = 1'b0;
  logic       ready_o, p_throttle_o, np_throttle_o, p_cred_err_o, np_cred_err_o;
  logic [7:0] p_thr_o, np_thr_o;
  logic [6:0] drop_cnt_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  int  m_cnt [2];
  int  m_thr [2];
  bit  m_err [2];
  bit  m_ready = 0;
  int  m_drop = 0;
  bit  last_rise = 0, last_rd = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  credit_throttle i_credit_throttle (.*);

  task automatic chk(input int got, input int exp, input string tag);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=%0d exp=%0d", tag, $time, got, exp);
    end
  endtask

  task automatic model_update();
    bit rise, inc, cons, ret;
    int ini, t;
    rise = link_up_i && !m_ready;
    for (int c = 0; c < 2; c++) begin
      cons = (c == 0) ? p_consume_i : np_consume_i;
      ret  = (c == 0) ? p_return_i  : np_return_i;
      ini  = (c == 0) ? int'(init_p_cred_i) : int'(init_np_cred_i);
      m_err[c] = cons && !ret && m_cnt[c] == 0;
      if (!link_up_i)       m_cnt[c] = 0;
      else if (rise)        m_cnt[c] = ini;
      else if (cons && !ret) m_cnt[c] = (m_cnt[c] > 0) ? m_cnt[c] - 1 : 0;
      else if (ret && !cons) m_cnt[c] = (m_cnt[c] < 255) ? m_cnt[c] + 1 : 255;
      t = thr_we_i[c] ? int'(thr_wdata_i) : m_thr[c];
      if (rise && ini < t) t = ini;
      m_thr[c] = t;
    end
    inc = m_ready && !link_up_i;
    if (drop_rd_i)  m_drop = inc ? 1 : 0;
    else if (inc)   m_drop = (m_drop < 127) ? m_drop + 1 : 127;
    m_ready   = link_up_i;
    last_rise = rise;
    last_rd   = drop_rd_i;
  endtask

  task automatic compare();
    chk(int'(p_throttle_o),  int'(!m_ready || m_cnt[0] < m_thr[0]), "R1 p_throttle");
    chk(int'(np_throttle_o), int'(!m_ready || m_cnt[1] < m_thr[1]), "R2 np_throttle");
    chk(int'(p_thr_o),  m_thr[0], last_rise ? "R4 p_thr clamp" : "R3 p_thr");
    chk(int'(np_thr_o), m_thr[1], last_rise ? "R4 np_thr clamp" : "R3 np_thr");
    chk(int'(ready_o), int'(m_ready), "R5 ready");
    chk(int'(p_cred_err_o),  int'(m_err[0]), "R7 p_err");
    chk(int'(np_cred_err_o), int'(m_err[1]), "R7 np_err");
    chk(int'(drop_cnt_o), m_drop, last_rd ? "R9 drop read" : "R8 drop count");
  endtask

  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare();
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int ilist [5] = '{0, 1, 3, 200, 255};
    int tlist [4] = '{0, 2, 5, 255};
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_thr[c] = 0; m_err[c] = 0;
    end
    #(CLK_P * 3);
    @(negedge clk_i);
    // reset state, R5: not ready, both throttled
    compare();
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 4; j++) begin
        // program thresholds while down
        thr_wdata_i = 8'(tlist[j]); thr_we_i = 2'b01; step();
        thr_wdata_i = 8'(tlist[(j + 1) % 4]); thr_we_i = 2'b10; step();
        thr_we_i = 2'b00;
        init_p_cred_i  = 8'(ilist[i]);
        init_np_cred_i = 8'(ilist[(i + 2) % 5]);
        link_up_i = 1'b1;
        // odd combos: write in link-up cycle, must be clamped (R4)
        if ((i + j) % 2 == 1) begin thr_wdata_i = 8'hF0; thr_we_i = 2'b01; end
        step();
        thr_we_i = 2'b00;
        // consume-biased phase, underflow and error (R6, R7)
        for (int k = 0; k < 300; k++) begin
          next_lfsr();
          p_consume_i  = lfsr[1:0] != 2'b00;
          p_return_i   = lfsr[2] & lfsr[3];
          np_consume_i = lfsr[5:4] != 2'b00;
          np_return_i  = lfsr[6] & lfsr[7];
          thr_we_i     = (k == 150) ? 2'b11 : 2'b00;
          thr_wdata_i  = lfsr[15:8];
          drop_rd_i    = (k == 77);
          step();
        end
        // return-biased phase, saturation at 255 (R6)
        for (int k = 0; k < 300; k++) begin
          next_lfsr();
          p_consume_i  = lfsr[0] & lfsr[1];
          p_return_i   = lfsr[3:2] != 2'b00;
          np_consume_i = lfsr[4] & lfsr[5];
          np_return_i  = lfsr[7:6] != 2'b00;
          thr_we_i     = (k == 280) ? 2'b11 : 2'b00;
          thr_wdata_i  = lfsr[15:8];
          drop_rd_i    = 1'b0;
          step();
        end
        p_consume_i = 0; p_return_i = 0; np_consume_i = 0; np_return_i = 0;
        thr_we_i = 2'b00;
        link_up_i = 1'b0;
        // consume while down: R7 error, R5 counts zero
        np_consume_i = 1'b1; step();
        np_consume_i = 1'b0; step();
      end
    end

    // drop counter clear, then saturation (R8)
    drop_rd_i = 1'b1; step(); drop_rd_i = 1'b0;
    for (int k = 0; k < 132; k++) begin
      link_up_i = 1'b1; step();
      link_up_i = 1'b0; step();
    end
    // read with no drop clears (R9)
    drop_rd_i = 1'b1; step(); drop_rd_i = 1'b0; step();
    link_up_i = 1'b1; step(); step();
    // read coinciding with a drop reloads one (R9)
    link_up_i = 1'b0; drop_rd_i = 1'b1; step();
    drop_rd_i = 1'b0; step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule